// File: doc/BRIEF.md
# Interrupt Vectoring Program Counter Unit

This block sequences the fetch address for a 2048-word instruction store with 16-bit words. It holds an 11-bit program counter that moves forward by one word each cycle, loads a target for jumps and calls, and restores a saved address on returns. A small hardware return stack holds up to four saved program counter values. It is changed only by calls, interrupt entries and returns, and nothing else can read or write it.

Four interrupt sources each have their own fixed entry address, spaced four words apart. The requests reach this block already synchronised and already masked per source. A request is served only when the unit's global interrupt enable is set, no branch or return is in flight, and the stack still has a free level. Otherwise the request simply waits. Entering a service routine saves the next sequential address and turns the global enable off. A return-from-interrupt turns it back on. The one-hot acknowledge output tells the outside flag logic which source was taken.

Top module: `pcu_vector_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `fetch_addr` becomes 0x000, the stack is emptied, `stack_full` goes low and the global enable is cleared, so no request is acknowledged until the enable is written.
- R2: In a cycle with no branch, no return and no acknowledge, the next `fetch_addr` is the current one plus one, and 0x7FF wraps to 0x000.
- R3: `br_valid` with `br_call` low loads `br_target` into `fetch_addr` on the next edge and leaves the stack unchanged.
- R4: `br_valid` with `br_call` high pushes the current address plus one and loads `br_target`. If the stack already holds four entries, the push is dropped but the jump still happens.
- R5: `ret_valid` pops the most recent entry into `fetch_addr`. With an empty stack it steps to the current address plus one and the depth stays zero. When `ret_from_irq` is high, the return also sets the global enable.
- R6: Entry addresses are fixed by `irq_req` bit: bit 0 goes to 0x004, bit 1 to 0x008, bit 2 to 0x00C and bit 3 to 0x010. `irq_ack` is one-hot on the source taken and zero otherwise.
- R7: A request is acknowledged only when the enable is set, `br_valid` and `ret_valid` are both low, and the stack holds fewer than four entries. Otherwise it is not acknowledged and stays pending for as long as its request line is held.
- R8: When several requests are eligible at once, the lowest bit (lowest entry address) wins.
- R9: Interrupt entry pushes the current address plus one and clears the global enable, so no second acknowledge follows in the next cycle.
- R10: `stack_full` is high exactly when the stack holds four entries.
- R11: `gie_wr` loads `gie_val` into the global enable. Clearing by an interrupt entry in the same cycle takes precedence over it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 4 | Per-source interrupt requests, bit 0 highest priority |
| gie_wr | input | 1 | Write strobe for the global interrupt enable |
| gie_val | input | 1 | Value written to the global enable |
| br_valid | input | 1 | Jump or call strobe |
| br_call | input | 1 | 1 = call (push return address), 0 = plain jump |
| br_target | input | 11 | Jump or call destination |
| ret_valid | input | 1 | Return strobe |
| ret_from_irq | input | 1 | Return is from an interrupt and re-enables interrupts |
| fetch_addr | output | 11 | Current instruction fetch address |
| stack_full | output | 1 | Return stack holds four entries |
| irq_ack | output | 4 | One-hot acknowledge of the source being taken |

## Verification
The hardest case to reach is a request that is eligible in every other respect (enable set, no branch or return) but blocked only because all four stack levels are in use. It must stay pending and then be taken right after a return frees a level. The stimulus gets there with four back-to-back calls, a fifth call whose push must be dropped, and an enable write while a request is held. One return then opens a level. Long random runs with frequent calls and rare returns keep revisiting the full stack, mixed with simultaneous multi-source requests and enable writes that collide with an entry.

// File: rtl/pcu_pkg.sv
// Package: shared types and helpers for the program counter unit.
// Assumes: one instruction per cycle; vectors start one stride above zero.
package pcu_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ  = 2'd0,
        SEL_JUMP = 2'd1,
        SEL_RET  = 2'd2,
        SEL_VEC  = 2'd3
    } pc_sel_e;

    // Entry offset of source idx: first source one stride above address zero.
    function automatic int unsigned vec_offset(input int unsigned idx,
                                               input int unsigned stride);
        return (idx + 1) * stride;
    endfunction

endpackage

// File: rtl/pcu_ret_stack.sv
// Module: hardware return stack of DEPTH program counter values.
// Assumes: push and pop never requested together; push when full and
// pop when empty are dropped without touching the level counter.
module pcu_ret_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] top,
    output logic          full,
    output logic          empty
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [AW-1:0] mem [DEPTH];
    logic [CW-1:0] level;
    logic          do_push;
    logic          do_pop;
    logic [IW-1:0] wr_idx;
    logic [IW-1:0] rd_idx;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty && !push;
    assign wr_idx  = IW'(level);
    assign rd_idx  = IW'(level - 1'b1);
    assign top     = mem[rd_idx];

    // Level counter: count accepted pushes and pops.
    always_ff @(posedge clk) begin
        if (!rst_n)       level <= '0;
        else if (do_push) level <= level + 1'b1;
        else if (do_pop)  level <= level - 1'b1;
    end

    // Storage write: accepted push lands in the next free slot.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_idx] <= push_data;
    end

endmodule

// File: rtl/pcu_irq_arb.sv
// Module: fixed-priority interrupt arbiter with vector generation.
// Assumes: requests already masked per source; lowest index wins.
module pcu_irq_arb #(
    parameter int AW     = 11,
    parameter int N_SRC  = 4,
    parameter int STRIDE = 4
) (
    input  logic [N_SRC-1:0] req,
    input  logic             allow,
    output logic [N_SRC-1:0] grant,
    output logic [AW-1:0]    vec
);
    import pcu_pkg::*;

    logic found;

    // Priority scan: first set request gets the grant and its vector.
    always_comb begin
        grant = '0;
        vec   = '0;
        found = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (allow && !found && req[i]) begin
                grant[i] = 1'b1;
                vec      = AW'(vec_offset(i, STRIDE));
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcu_next_pc.sv
// Module: next program counter selection.
// Assumes: a return on an empty stack behaves as a sequential step.
module pcu_next_pc #(
    parameter int AW = 11
) (
    input  logic [AW-1:0]    pc,
    input  pcu_pkg::pc_sel_e sel,
    input  logic [AW-1:0]    target,
    input  logic [AW-1:0]    ret_addr,
    input  logic             stack_empty,
    input  logic [AW-1:0]    vec,
    output logic [AW-1:0]    seq,
    output logic [AW-1:0]    nxt
);
    import pcu_pkg::*;

    assign seq = pc + 1'b1;

    // Source mux for the next fetch address.
    always_comb begin
        unique case (sel)
            SEL_JUMP: nxt = target;
            SEL_RET:  nxt = stack_empty ? seq : ret_addr;
            SEL_VEC:  nxt = vec;
            default:  nxt = seq;
        endcase
    end

endmodule

// File: rtl/pcu_vector_unit.sv
// Module: program counter unit with return stack and interrupt vectoring.
// Assumes: one strobe (branch or return) per cycle at most; requests are
// synchronised and masked; interrupts taken only at plain sequential steps.
module pcu_vector_unit #(
    parameter int AW     = 11,
    parameter int DEPTH  = 4,
    parameter int N_SRC  = 4,
    parameter int STRIDE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] irq_req,
    input  logic             gie_wr,
    input  logic             gie_val,
    input  logic             br_valid,
    input  logic             br_call,
    input  logic [AW-1:0]    br_target,
    input  logic             ret_valid,
    input  logic             ret_from_irq,
    output logic [AW-1:0]    fetch_addr,
    output logic             stack_full,
    output logic [N_SRC-1:0] irq_ack
);
    import pcu_pkg::*;

    logic [AW-1:0] pc_q;
    logic [AW-1:0] pc_d;
    logic [AW-1:0] seq_addr;
    logic [AW-1:0] vec_addr;
    logic [AW-1:0] stk_top;
    logic          stk_full;
    logic          stk_empty;
    logic          irq_en_q;
    logic          allow;
    logic          take;
    logic          push;
    logic          pop;
    pc_sel_e       sel;

    assign allow = irq_en_q && !br_valid && !ret_valid && !stk_full;
    assign take  = |irq_ack;
    assign push  = take || (br_valid && br_call && !ret_valid);
    assign pop   = ret_valid && !take;

    // Select decode: interrupt, then return, then branch, else step.
    always_comb begin
        if (take)           sel = SEL_VEC;
        else if (ret_valid) sel = SEL_RET;
        else if (br_valid)  sel = SEL_JUMP;
        else                sel = SEL_SEQ;
    end

    pcu_irq_arb #(.AW(AW), .N_SRC(N_SRC), .STRIDE(STRIDE)) u_arb (
        .req   (irq_req),
        .allow (allow),
        .grant (irq_ack),
        .vec   (vec_addr)
    );

    pcu_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (seq_addr),
        .pop       (pop),
        .top       (stk_top),
        .full      (stk_full),
        .empty     (stk_empty)
    );

    pcu_next_pc #(.AW(AW)) u_next (
        .pc          (pc_q),
        .sel         (sel),
        .target      (br_target),
        .ret_addr    (stk_top),
        .stack_empty (stk_empty),
        .vec         (vec_addr),
        .seq         (seq_addr),
        .nxt         (pc_d)
    );

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    // Global enable: entry clears, interrupt return sets, else software write.
    always_ff @(posedge clk) begin
        if (!rst_n)                         irq_en_q <= 1'b0;
        else if (take)                      irq_en_q <= 1'b0;
        else if (ret_valid && ret_from_irq) irq_en_q <= 1'b1;
        else if (gie_wr)                    irq_en_q <= gie_val;
    end

    assign fetch_addr = pc_q;
    assign stack_full = stk_full;

endmodule

// File: rtl/pcu_vector_unit_chk.sv
// Module: assertion checker for the program counter unit, bound below.
// Assumes: same parameters as the unit it watches.
module pcu_vector_unit_chk #(
    parameter int AW     = 11,
    parameter int N_SRC  = 4,
    parameter int STRIDE = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] irq_req,
    input logic             br_valid,
    input logic             ret_valid,
    input logic [AW-1:0]    fetch_addr,
    input logic             stack_full,
    input logic [N_SRC-1:0] irq_ack
);
    localparam int MAX_VEC = N_SRC * STRIDE;

    p_ack_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_ack));

    p_ack_has_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |-> ((irq_ack & irq_req) == irq_ack));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_full || br_valid || ret_valid) |-> (irq_ack == '0));

    p_vector_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |=> ((int'(fetch_addr) % STRIDE == 0) &&
                             (fetch_addr != '0) &&
                             (int'(fetch_addr) <= MAX_VEC)));

    p_no_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |=> (irq_ack == '0));

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!br_valid && !ret_valid && irq_ack == '0)
        |=> (fetch_addr == AW'($past(fetch_addr) + 1'b1)));

endmodule

bind pcu_vector_unit pcu_vector_unit_chk #(
    .AW(AW), .N_SRC(N_SRC), .STRIDE(STRIDE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req    (irq_req),
    .br_valid   (br_valid),
    .ret_valid  (ret_valid),
    .fetch_addr (fetch_addr),
    .stack_full (stack_full),
    .irq_ack    (irq_ack)
);

// File: tb/pcu_vector_unit_test.sv
`timescale 1ns/1ps
module pcu_vector_unit_test;
    localparam int AW = 11;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_req = '0;
    logic          gie_wr = 1'b0, gie_val = 1'b0;
    logic          br_valid = 1'b0, br_call = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic          ret_valid = 1'b0, ret_from_irq = 1'b0;
    logic [AW-1:0] fetch_addr;
    logic          stack_full;
    logic [NS-1:0] irq_ack;

    int checks = 0;
    int errors = 0;

    // Reference state built from the requirements.
    logic [AW-1:0] m_pc;
    logic [AW-1:0] m_stk [4];
    int            m_dep;
    logic          m_en;

    always #4 clk = ~clk;

    pcu_vector_unit uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .gie_wr(gie_wr),
        .gie_val(gie_val), .br_valid(br_valid), .br_call(br_call),
        .br_target(br_target), .ret_valid(ret_valid),
        .ret_from_irq(ret_from_irq), .fetch_addr(fetch_addr),
        .stack_full(stack_full), .irq_ack(irq_ack)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected acknowledge: lowest eligible request (R6, R7, R8).
    function automatic logic [NS-1:0] exp_ack(input logic [NS-1:0] req,
                                              input bit bv, input bit rv);
        logic [NS-1:0] g = '0;
        if (m_en && !bv && !rv && m_dep < 4)
            for (int i = 0; i < NS; i++)
                if (req[i] && g == '0) g[i] = 1'b1;
        return g;
    endfunction

    function automatic int ack_idx(input logic [NS-1:0] g);
        for (int i = 0; i < NS; i++) if (g[i]) return i;
        return -1;
    endfunction

    // One instruction cycle: drive, check ack, clock, update model, check.
    task automatic step(input logic [NS-1:0] req, input bit gwr, input bit gval,
                        input bit bv, input bit bc, input logic [AW-1:0] bt,
                        input bit rv, input bit rfi, input string tag);
        logic [NS-1:0] ea;
        int            k;
        irq_req = req; gie_wr = gwr; gie_val = gval;
        br_valid = bv; br_call = bc; br_target = bt;
        ret_valid = rv; ret_from_irq = rfi;
        ea = exp_ack(req, bv, rv);
        #1;
        check(irq_ack == ea, {tag, " R7 R8 ack"}, irq_ack, ea);
        @(posedge clk);
        k = ack_idx(ea);
        if (k >= 0) begin
            m_stk[m_dep] = m_pc + 1'b1; m_dep++;
            m_pc = AW'((k + 1) * 4);
            m_en = 1'b0;
        end else if (rv) begin
            if (m_dep > 0) begin m_dep--; m_pc = m_stk[m_dep]; end
            else m_pc = m_pc + 1'b1;
            if (rfi) m_en = 1'b1;
            else if (gwr) m_en = gval;
        end else begin
            if (gwr) m_en = gval;
            if (bv) begin
                if (bc && m_dep < 4) begin m_stk[m_dep] = m_pc + 1'b1; m_dep++; end
                m_pc = bt;
            end else m_pc = m_pc + 1'b1;
        end
        @(negedge clk);
        check(fetch_addr == m_pc, {tag, " pc"}, fetch_addr, m_pc);
        check(stack_full == (m_dep == 4), {tag, " R10 full"}, stack_full, (m_dep == 4));
    endtask

    task automatic idle(input string tag);
        step('0, 0, 0, 0, 0, '0, 0, 0, tag);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check(fetch_addr == '0, "R1 reset addr", fetch_addr, 0);
        check(stack_full == 1'b0, "R1 reset full", stack_full, 0);
        m_pc = '0; m_dep = 0; m_en = 1'b0;
        rst_n = 1'b1;

        // R1: enable cleared after reset, so a request is not taken.
        step(4'b0001, 0, 0, 0, 0, '0, 0, 0, "R1");
        idle("R2");
        // R3 jump near the top, then R2 wrap.
        step('0, 0, 0, 1, 0, 11'h7FE, 0, 0, "R3");
        idle("R2"); idle("R2 wrap");
        // R5 return on empty stack.
        step('0, 0, 0, 0, 0, '0, 1, 0, "R5 empty");
        // R4 four calls fill the stack; fifth push dropped.
        for (int i = 0; i < 5; i++)
            step('0, 0, 0, 1, 1, AW'(12'h100 + 12'h40 * i), 0, 0, "R4");
        // R11 enable write while full; R7 request held but blocked.
        step('0, 1, 1, 0, 0, '0, 0, 0, "R11");
        step(4'b0100, 0, 0, 0, 0, '0, 0, 0, "R7 full");
        step(4'b0100, 0, 0, 0, 0, '0, 1, 0, "R5 pop");
        step(4'b0100, 0, 0, 0, 0, '0, 0, 0, "R9 R6 taken");
        step(4'b0100, 0, 0, 0, 0, '0, 0, 0, "R9 disabled");
        for (int i = 0; i < 5; i++)
            step('0, 0, 0, 0, 0, '0, 1, (i == 0), "R5 unwind");
        // R8 priority and each R6 vector.
        for (int i = 0; i < NS; i++) begin
            step('0, 1, 1, 0, 0, '0, 0, 0, "R11 set");
            step(4'b1111 << i, 0, 0, 0, 0, '0, 0, 0, "R8 R6 vector");
            step('0, 0, 0, 0, 0, '0, 1, 1, "R5 reti");
        end
        // R11 entry clear beats a same-cycle write of 1.
        step(4'b1000, 1, 1, 0, 0, '0, 0, 0, "R11 collide");
        step(4'b1000, 0, 0, 0, 0, '0, 0, 0, "R11 stays off");
        step('0, 0, 0, 0, 0, '0, 1, 1, "R5 reti");

        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            int unsigned r = $urandom;
            logic [NS-1:0] rq = (r[3:0] < 6) ? '0 : NS'($urandom);
            bit bv = (r[7:4] < 3);
            bit rv = !bv && (r[11:8] < 2);
            step(rq, (r[15:12] == 0), r[16], bv, r[17], AW'($urandom),
                 rv, r[18], "rand R2 R3 R4 R5");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule